// File: doc/BRIEF.md
# Queued Serial Transfer Sequencer

This block runs a serial peripheral master from a command queue. Host software fills a small store with transmit words and command words, sets a last-entry pointer and an enable bit, and the sequencer then steps through the queue without further help. For each entry it hands the transmit word and the command word to a separate shift engine, waits for that engine to report the transfer finished, files the received word at the entry's own index, records that index as the most recently completed entry, and advances its working pointer. The serial bit timing, clock polarity and per-transfer delays all belong to the shift engine; this block only forwards the command bits that select them.

Between transfers the block drives the chip-select outputs. An entry can ask for its pattern to stay asserted until the next transfer begins, or it can let the lines return to an idle pattern held in a register. At the last entry the block raises a completion flag and an optional interrupt. It then either stops and clears its own enable, or starts again at entry 0 when continuous mode is on. The flag can only be cleared by a status read that sees it set, followed by a status write with a zero in the flag bit.

The handoff to the shift engine is a valid/ready stream. `xfer_valid` rises with the transmit and command words. These stay unchanged until a cycle in which `xfer_ready` is high, and that cycle is the start of the transfer. The engine can hold off a transfer for as long as it needs by keeping `xfer_ready` low. The return path has no back-pressure: `xfer_done` is a one-cycle pulse carrying `xfer_rx`, and the block always accepts it.

Top module: `qseq_ctrl`

## Requirements
- R1: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_tx` and `xfer_cmd` hold their values. The words offered are the transmit word and the command word of the entry selected by the working pointer. Command bits: [3:0] chip-select pattern, [4] continue, [5] length select, [6] pre-clock delay, [7] post-transfer delay.
- R2: On an `xfer_done` pulse, `xfer_rx` is written to receive slot N, where N is the index of the active entry, and N is copied into status bits [7:4].
- R3: After a transfer completes, the working pointer becomes N+1. After the last entry (index equal to the end pointer) it becomes 0.
- R4: A host write to the working pointer made after the current entry was fetched sets the next entry to run, and the automatic advance is suppressed for that transfer.
- R5: From the cycle after a transfer is accepted, `cs_n` shows that entry's pattern. If the entry has continue set, the pattern is held after the transfer ends and changes only when the next transfer is accepted.
- R6: After a transfer whose continue bit is clear, or after the queue halts, `cs_n` shows the idle pattern register (reset value 4'hF).
- R7: Completing the last entry sets the status flag (bit 0), whether continuous mode is on or off.
- R8: With continuous mode off, completing the last entry clears control enable bit 0, and no further transfer is offered.
- R9: With continuous mode on (control bit 1), the block keeps its enable set and keeps cycling. New receive words overwrite the old ones even while the flag is set.
- R10: `irq` is set when the flag is set while interrupt enable (control bit 2) is 1. Clearing the interrupt enable afterwards does not remove a pending `irq`. `irq` falls when the flag is cleared.
- R11: The flag clears only when a status read that returned the flag set is followed by a status write with bit 0 equal to 0. A write of 0 without such a read leaves the flag set.
- R12: Host map on `host_addr[5:4]`:
  - 0: transmit words.
  - 1: command words.
  - 2: receive words (read only).
  - 3: registers, selected by `host_addr[3:0]`:
    - 0: control.
    - 1: working pointer.
    - 2: end pointer.
    - 3: status.
    - 4: idle pattern.

  `host_rdata` is valid in the cycle after `host_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 6 | Host address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| xfer_valid | output | 1 | A transfer is offered to the shift engine |
| xfer_ready | input | 1 | Shift engine accepts the offered transfer |
| xfer_tx | output | 16 | Transmit word of the offered transfer |
| xfer_cmd | output | 8 | Command word of the offered transfer |
| xfer_done | input | 1 | One-cycle pulse: transfer finished |
| xfer_rx | input | 16 | Received word, valid with `xfer_done` |
| cs_n | output | 4 | Chip-select outputs |
| irq | output | 1 | Completion interrupt request |

## Verification
Results fall due at fixed distances from their stimuli:

- **Flag, completed index, receive slot and pointer:** these take effect on the clock edge that samples `xfer_done`.
- **Chip-select pattern:** it changes on the edge that samples `xfer_ready` or `xfer_done`.
- **Next offer:** it appears two edges after `done`, one edge to return to idle and one to fetch.
- **Register reads:** they return one edge after `host_re`.

The bench drives every input on the falling edge and reads on the falling edge that follows the edge in question. Its engine model logs the transmit word and `cs_n` in the half cycle after each acceptance, and logs `cs_n` again in the half cycle after each completion. The checks compare these logs with the patterns the queue contents dictate.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int CSW  = 4;
  localparam int CMDW = 8;
  localparam int AW   = 6;

  typedef struct packed {
    logic           post_dly;
    logic           pre_dly;
    logic           len_sel;
    logic           cont;
    logic [CSW-1:0] cs;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_BUSY} seq_st_t;

  localparam logic [1:0] RG_TX  = 2'd0;
  localparam logic [1:0] RG_CMD = 2'd1;
  localparam logic [1:0] RG_RX  = 2'd2;
  localparam logic [1:0] RG_CSR = 2'd3;

  localparam logic [3:0] CSR_CTRL = 4'd0;
  localparam logic [3:0] CSR_WPTR = 4'd1;
  localparam logic [3:0] CSR_ENDP = 4'd2;
  localparam logic [3:0] CSR_STAT = 4'd3;
  localparam logic [3:0] CSR_IDLE = 4'd4;
endpackage

// File: rtl/qseq_store.sv
module qseq_store
  import qseq_pkg::*;
#(
  parameter int DW = 16,
  parameter int QD = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_we,
  input  logic                  cmd_we,
  input  logic [$clog2(QD)-1:0] wr_idx,
  input  logic [DW-1:0]         wr_data,
  input  logic                  rx_we,
  input  logic [$clog2(QD)-1:0] rx_idx,
  input  logic [DW-1:0]         rx_data,
  input  logic [$clog2(QD)-1:0] fetch_idx,
  output logic [DW-1:0]         fetch_tx,
  output logic [CMDW-1:0]       fetch_cmd,
  input  logic [$clog2(QD)-1:0] host_idx,
  output logic [DW-1:0]         host_tx,
  output logic [CMDW-1:0]       host_cmd,
  output logic [DW-1:0]         host_rx
);
  logic [DW-1:0]   tx_mem  [QD];
  logic [CMDW-1:0] cmd_mem [QD];
  logic [DW-1:0]   rx_mem  [QD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QD; i++) begin
        tx_mem[i]  <= '0;
        cmd_mem[i] <= '0;
        rx_mem[i]  <= '0;
      end
    end else begin
      if (tx_we)  tx_mem[wr_idx]  <= wr_data;
      if (cmd_we) cmd_mem[wr_idx] <= wr_data[CMDW-1:0];
      if (rx_we)  rx_mem[rx_idx]  <= rx_data;
    end
  end

  assign fetch_tx  = tx_mem[fetch_idx];
  assign fetch_cmd = cmd_mem[fetch_idx];
  assign host_tx   = tx_mem[host_idx];
  assign host_cmd  = cmd_mem[host_idx];
  assign host_rx   = rx_mem[host_idx];
endmodule

// File: rtl/qseq_csdrv.sv
module qseq_csdrv
  import qseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic [CSW-1:0] accept_pat,
  input  logic           done,
  input  logic           done_cont,
  input  logic           halt,
  input  logic [CSW-1:0] idle_pat,
  output logic [CSW-1:0] cs_n
);
  logic           hold_q;
  logic [CSW-1:0] pat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      pat_q  <= '1;
    end else if (accept) begin
      hold_q <= 1'b1;
      pat_q  <= accept_pat;
    end else if (done) begin
      hold_q <= done_cont && !halt;
    end
  end

  assign cs_n = hold_q ? pat_q : idle_pat;

  a_r5_accept_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cs_n == $past(accept_pat));
  a_r5_cont_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_cont && !halt |=> $stable(cs_n));
  a_r6_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    done && (!done_cont || halt) |=> cs_n == idle_pat);
endmodule

// File: rtl/qseq_flag.sv
module qseq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic irq_en,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic stat_wbit,
  output logic flag,
  output logic irq
);
  logic armed_q;
  logic clr;

  assign clr = stat_wr && armed_q && !stat_wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      irq     <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (stat_wr)              armed_q <= 1'b0;
      else if (stat_rd && flag) armed_q <= 1'b1;
      if (set_evt)              flag <= 1'b1;
      else if (clr)             flag <= 1'b0;
      if (set_evt && irq_en)    irq <= 1'b1;
      else if (clr && !set_evt) irq <= 1'b0;
    end
  end

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !stat_wr |=> irq);
  a_r11_clear_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(stat_wr && !stat_wbit && armed_q));
  a_r7_set_event: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
endmodule

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qseq_pkg::*;
#(
  parameter int DW = 16,
  parameter int QD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic            host_re,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            xfer_valid,
  input  logic            xfer_ready,
  output logic [DW-1:0]   xfer_tx,
  output logic [CMDW-1:0] xfer_cmd,
  input  logic            xfer_done,
  input  logic [DW-1:0]   xfer_rx,
  output logic [CSW-1:0]  cs_n,
  output logic            irq
);
  localparam int PW = $clog2(QD);
  localparam logic [PW-1:0] ONE = PW'(1);

  seq_st_t         st;
  logic            ctrl_en, ctrl_wrap, ctrl_irqen;
  logic [PW-1:0]   wptr, endp, cptr, cur_idx;
  logic            ovr;
  logic [CSW-1:0]  idle_pat;
  logic [DW-1:0]   iss_tx;
  cmd_t            iss_cmd;

  logic [1:0]      rg;
  logic [3:0]      csr;
  logic [PW-1:0]   hidx;
  logic            csr_wr, ctrl_wr, wptr_wr;
  logic            launch, accept, done_evt, at_end, halt;
  logic [DW-1:0]   fetch_tx, host_tx, host_rx;
  logic [CMDW-1:0] fetch_cmd, host_cmd;
  logic            flag;

  assign rg      = host_addr[AW-1:AW-2];
  assign csr     = host_addr[3:0];
  assign hidx    = host_addr[PW-1:0];
  assign csr_wr  = host_we && rg == RG_CSR;
  assign ctrl_wr = csr_wr && csr == CSR_CTRL;
  assign wptr_wr = csr_wr && csr == CSR_WPTR;

  assign launch   = st == ST_IDLE && ctrl_en;
  assign accept   = st == ST_ISSUE && xfer_ready;
  assign done_evt = st == ST_BUSY && xfer_done;
  assign at_end   = cur_idx == endp;
  assign halt     = done_evt && at_end && !ctrl_wrap;

  qseq_store #(.DW(DW), .QD(QD)) u_store (
    .clk(clk), .rst_n(rst_n),
    .tx_we(host_we && rg == RG_TX), .cmd_we(host_we && rg == RG_CMD),
    .wr_idx(hidx), .wr_data(host_wdata),
    .rx_we(done_evt), .rx_idx(cur_idx), .rx_data(xfer_rx),
    .fetch_idx(wptr), .fetch_tx(fetch_tx), .fetch_cmd(fetch_cmd),
    .host_idx(hidx), .host_tx(host_tx), .host_cmd(host_cmd), .host_rx(host_rx)
  );

  qseq_csdrv u_cs (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .accept_pat(iss_cmd.cs),
    .done(done_evt), .done_cont(iss_cmd.cont), .halt(halt),
    .idle_pat(idle_pat), .cs_n(cs_n)
  );

  qseq_flag u_flag (
    .clk(clk), .rst_n(rst_n),
    .set_evt(done_evt && at_end), .irq_en(ctrl_irqen),
    .stat_rd(host_re && rg == RG_CSR && csr == CSR_STAT),
    .stat_wr(csr_wr && csr == CSR_STAT), .stat_wbit(host_wdata[0]),
    .flag(flag), .irq(irq)
  );

  // Sequencer state and the entry latched for the shift engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur_idx <= '0;
      iss_tx  <= '0;
      iss_cmd <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (ctrl_en) begin
          st      <= ST_ISSUE;
          cur_idx <= wptr;
          iss_tx  <= fetch_tx;
          iss_cmd <= cmd_t'(fetch_cmd);
        end
        ST_ISSUE: if (xfer_ready) st <= ST_BUSY;
        ST_BUSY:  if (xfer_done)  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // Pointers, control and idle pattern
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_wrap  <= 1'b0;
      ctrl_irqen <= 1'b0;
      wptr       <= '0;
      endp       <= '0;
      cptr       <= '0;
      ovr        <= 1'b0;
      idle_pat   <= '1;
    end else begin
      if (launch) ovr <= 1'b0;
      if (wptr_wr) begin
        wptr <= host_wdata[PW-1:0];
        ovr  <= 1'b1;
      end else if (done_evt && !ovr) begin
        wptr <= at_end ? '0 : cur_idx + ONE;
      end
      if (done_evt) cptr <= cur_idx;
      if (csr_wr && csr == CSR_ENDP) endp <= host_wdata[PW-1:0];
      if (csr_wr && csr == CSR_IDLE) idle_pat <= host_wdata[CSW-1:0];
      if (ctrl_wr) begin
        ctrl_en    <= host_wdata[0];
        ctrl_wrap  <= host_wdata[1];
        ctrl_irqen <= host_wdata[2];
      end
      if (halt) ctrl_en <= 1'b0;
    end
  end

  // Registered host read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_re) begin
      unique case (rg)
        RG_TX:  host_rdata <= host_tx;
        RG_CMD: host_rdata <= {{(DW-CMDW){1'b0}}, host_cmd};
        RG_RX:  host_rdata <= host_rx;
        default: begin
          unique case (csr)
            CSR_CTRL: host_rdata <= {{(DW-3){1'b0}}, ctrl_irqen, ctrl_wrap, ctrl_en};
            CSR_WPTR: host_rdata <= {{(DW-PW){1'b0}}, wptr};
            CSR_ENDP: host_rdata <= {{(DW-PW){1'b0}}, endp};
            CSR_STAT: host_rdata <= {{(DW-4-PW){1'b0}}, cptr, 3'b000, flag};
            CSR_IDLE: host_rdata <= {{(DW-CSW){1'b0}}, idle_pat};
            default:  host_rdata <= '0;
          endcase
        end
      endcase
    end
  end

  assign xfer_valid = st == ST_ISSUE;
  assign xfer_tx    = iss_tx;
  assign xfer_cmd   = iss_cmd;

  a_r1_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_tx) && $stable(xfer_cmd));
  a_r2_completed_index: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> cptr == $past(cur_idx));
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !ovr && !wptr_wr && !at_end |=> wptr == $past(cur_idx) + ONE);
  a_r4_override_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_wr |=> wptr == $past(host_wdata[PW-1:0]));
  a_r8_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !ctrl_en && !xfer_valid);
  a_r9_wrap_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && at_end && ctrl_wrap && !ctrl_wr |=> ctrl_en);
endmodule

// File: tb/qseq_ctrl_bench.sv
`timescale 1ns/1ps
module qseq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [15:0] xfer_tx;
  logic [7:0]  xfer_cmd;
  logic        xfer_done = 1'b0;
  logic [15:0] xfer_rx = '0;
  logic [3:0]  cs_n;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  int n_acc = 0, n_done = 0;
  logic [15:0] acc_tx [64];
  logic [3:0]  acc_cs [64];
  logic [3:0]  gap_cs [64];
  logic        eng_busy = 1'b0;
  int          eng_cnt = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  qseq_ctrl u_qseq_ctrl (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_tx(xfer_tx),
    .xfer_cmd(xfer_cmd), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
    .cs_n(cs_n), .irq(irq)
  );

  // Shift engine model: accepts after one half cycle, finishes four cycles later
  always @(negedge clk) begin
    if (xfer_done) begin
      xfer_done = 1'b0;
      gap_cs[n_done & 63] = cs_n;
      n_done++;
    end
    if (xfer_ready) begin
      xfer_ready = 1'b0;
      eng_busy = 1'b1;
      eng_cnt = 4;
      acc_tx[n_acc & 63] = xfer_tx;
      acc_cs[n_acc & 63] = cs_n;
      n_acc++;
    end else if (eng_busy) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        eng_busy = 1'b0;
        xfer_done = 1'b1;
        xfer_rx = acc_tx[(n_acc - 1) & 63] ^ 16'hA5A5;
      end
    end else if (xfer_valid && rst_n) begin
      xfer_ready = 1'b1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_halt();
    logic [15:0] d;
    for (int i = 0; i < 500; i++) begin
      host_rd(6'h30, d);
      if (d[0] == 1'b0) return;
    end
    check("R8 halt timeout", 1, 0);
  endtask

  task automatic wait_done(int target);
    for (int i = 0; i < 2000 && n_done < target; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    logic [15:0] d;
    host_rd(6'h33, d);
    host_wr(6'h33, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R6 reset cs_n idle", cs_n, 4'hF);
    check("R10 reset irq", irq, 0);
    check("R1 reset no offer", xfer_valid, 0);
    host_rd(6'h33, d);
    check("R12 reset status", d, 0);
    host_rd(6'h34, d);
    check("R12 idle pattern read", d, 16'h000F);
  endtask

  task automatic t_queue_cs();
    logic [15:0] d;
    int b = n_acc;
    for (int i = 0; i < 4; i++) host_wr(6'(i), 16'h1000 + 16'(i));
    host_wr(6'h10, 16'h001E);
    host_wr(6'h11, 16'h001E);
    host_wr(6'h12, 16'h001D);
    host_wr(6'h13, 16'h000B);
    host_wr(6'h32, 16'h0003);
    host_wr(6'h30, 16'h0005);
    wait_halt();
    check("R1 transfer count", n_acc - b, 4);
    for (int i = 0; i < 4; i++) begin
      check("R1 order of offered words", acc_tx[(b + i) & 63], 16'h1000 + 16'(i));
      host_rd(6'(32 + i), d);
      check("R2 receive slot", d, (16'h1000 + 16'(i)) ^ 16'hA5A5);
    end
    check("R5 cs entry0", acc_cs[b & 63], 4'hE);
    check("R5 cs held after entry0", gap_cs[b & 63], 4'hE);
    check("R5 cs held after entry1", gap_cs[(b + 1) & 63], 4'hE);
    check("R5 cs switches at entry2", acc_cs[(b + 2) & 63], 4'hD);
    check("R5 cs held after entry2", gap_cs[(b + 2) & 63], 4'hD);
    check("R5 cs entry3", acc_cs[(b + 3) & 63], 4'hB);
    check("R6 cs idle after cont clear", gap_cs[(b + 3) & 63], 4'hF);
    host_rd(6'h31, d);
    check("R3 pointer back to 0", d, 0);
    repeat (30) @(negedge clk);
    check("R8 no offers after halt", n_acc - b, 4);
    check("R10 irq raised", irq, 1);
    host_wr(6'h33, 16'h0000);
    host_rd(6'h33, d);
    check("R11 flag kept without read", d[0], 1);
    check("R2 completed index", d[7:4], 3);
    host_wr(6'h33, 16'h0000);
    host_rd(6'h33, d);
    check("R11 flag cleared", d[0], 0);
    check("R10 irq follows flag", irq, 0);
  endtask

  task automatic t_irq_mask();
    logic [15:0] d;
    host_wr(6'h30, 16'h0005);
    wait_halt();
    check("R7 flag set again", irq, 1);
    host_wr(6'h30, 16'h0000);
    repeat (3) @(negedge clk);
    check("R10 pending irq survives mask", irq, 1);
    clear_flag();
    check("R10 irq drops on clear", irq, 0);
    host_wr(6'h30, 16'h0001);
    wait_halt();
    host_rd(6'h33, d);
    check("R7 flag set with irq off", d[0], 1);
    check("R10 no irq when masked", irq, 0);
    clear_flag();
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    int b = n_done;
    host_wr(6'h00, 16'h1111);
    host_wr(6'h01, 16'h2222);
    host_wr(6'h32, 16'h0001);
    host_wr(6'h30, 16'h0003);
    wait_done(b + 3);
    host_wr(6'h00, 16'h3333);
    wait_done(b + 8);
    host_rd(6'h30, d);
    check("R9 enable kept", d[0], 1);
    host_rd(6'h33, d);
    check("R7 flag in wrap mode", d[0], 1);
    host_rd(6'h20, d);
    check("R9 receive overwritten", d, 16'h3333 ^ 16'hA5A5);
    host_wr(6'h30, 16'h0000);
    repeat (30) @(negedge clk);
    clear_flag();
    host_wr(6'h31, 16'h0000);
  endtask

  task automatic t_override();
    logic [15:0] d;
    int b = n_acc;
    for (int i = 0; i < 4; i++) host_wr(6'(i), 16'h4000 + 16'(i));
    host_wr(6'h32, 16'h0003);
    host_wr(6'h30, 16'h0001);
    for (int i = 0; i < 200 && n_acc == b; i++) @(negedge clk);
    host_wr(6'h31, 16'h0002);
    wait_halt();
    check("R4 transfers after override", n_acc - b, 3);
    check("R4 first entry", acc_tx[b & 63], 16'h4000);
    check("R4 jumped entry", acc_tx[(b + 1) & 63], 16'h4002);
    check("R3 step after jump", acc_tx[(b + 2) & 63], 16'h4003);
    check("R6 idle after halt", cs_n, 4'hF);
    clear_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_queue_cs();
    t_irq_mask();
    t_wrap();
    t_override();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule